// File: doc/BRIEF.md
# Packed Dot Product Accumulator

This block is a wide integer multiply-accumulate stage for a vector datapath. The source and accumulator vectors are each split into 32-bit lanes. In each lane the block multiplies small integer pairs taken from two source vectors and sums the products. It then adds that sum to the incoming accumulator lane. There are two lane formats. Byte format gives a four-way mixed-sign product: unsigned bytes times signed bytes. Word format gives a two-way product of signed 16-bit words.

Per operation, a control input chooses how the final add handles overflow: it either wraps or clamps. A per-lane write mask chooses which lanes take the new value. When masking is active, each unselected lane either becomes zero or passes the old accumulator through. The result appears two clock cycles after the operation is presented, with a valid flag beside it. New operations may be issued on every cycle.

Top module: `dpa_top`

## Requirements
- R1: With `word_mode`=0, lane L (bits 32L+31..32L) computes acc + sum over j=0..3 of unsigned(src_a byte j) × signed(src_b byte j), where byte j of a lane is bits 8j+7..8j within that lane.
- R2: With `word_mode`=1, lane L computes acc + sum over w=0..1 of signed(src_a word w) × signed(src_b word w), where word w is bits 16w+15..16w within that lane.
- R3: With `sat_en`=0, the lane result is the low 32 bits of the exact sum, so it wraps modulo 2^32.
- R4: With `sat_en`=1, the exact sum of the accumulator and all products is clamped to [-2^31, 2^31-1]. The clamp applies only to that final sum. A product sum that leaves the 32-bit range by itself, but returns into range once the accumulator is added, is not clamped.
- R5: With `mask_en`=1 and `zero_fill`=1, every lane L whose `lane_mask` bit L is 0 outputs zero.
- R6: With `mask_en`=1 and `zero_fill`=0, every lane L whose `lane_mask` bit L is 0 outputs its `acc_in` lane unchanged.
- R7: With `mask_en`=0, every lane is updated, whatever values `lane_mask` and `zero_fill` hold.
- R8: An operation sampled with `in_valid`=1 at a rising edge produces `out_valid`=1 and its result after the second rising edge. Operations may be issued on consecutive cycles. `out_valid` is 0 in cycles without a result, and `acc_out` holds its last value in those cycles.
- R9: After synchronous reset, `out_valid` is 0 and `acc_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| word_mode | input | 1 | 0: byte format, 1: word format |
| sat_en | input | 1 | 1: clamp the final add, 0: wrap |
| zero_fill | input | 1 | Unselected lanes: 1 zero, 0 keep accumulator |
| mask_en | input | 1 | 1: apply lane_mask, 0: update all lanes |
| lane_mask | input | LANES | Per-lane select, bit L for lane L |
| acc_in | input | 32*LANES | Accumulator vector |
| src_a | input | 32*LANES | First source (unsigned bytes / signed words) |
| src_b | input | 32*LANES | Second source (signed bytes / signed words) |
| out_valid | output | 1 | Result valid |
| acc_out | output | 32*LANES | Result vector |

## Verification
A bad lane product or a bad sign extension would show as a wrong value in that lane only, in the `acc_out` of the same operation, two cycles after issue. A stale or missing mask and control register in the first stage would show one operation too late. The bench sends operations back to back with different masks and modes to expose this. A broken valid pipeline would show as `out_valid` one cycle early or late, or as `acc_out` changing in a cycle without a result.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  localparam int LANE_W  = 32;              // accumulator lane width
  localparam int BYTES_L = LANE_W / 8;      // byte pairs per lane
  localparam int WORDS_L = LANE_W / 16;     // word pairs per lane
  localparam int BPROD_W = 17;              // unsigned8 x signed8
  localparam int WPROD_W = 32;              // signed16 x signed16
  localparam int SUM_W   = WPROD_W + 2;     // product sum, both formats
  localparam int TOT_W   = SUM_W + 1;       // accumulator + product sum
  typedef logic [LANE_W-1:0]        lane_t;
  typedef logic signed [SUM_W-1:0]  psum_t;
  typedef logic signed [TOT_W-1:0]  tot_t;
endpackage

// File: rtl/dpa_lane_mul.sv
module dpa_lane_mul
  import dpa_pkg::*;
(
  input  lane_t a,
  input  lane_t b,
  input  logic  word_mode,
  output psum_t psum
);
  logic signed [BPROD_W-1:0] pb [BYTES_L];
  logic signed [WPROD_W-1:0] pw [WORDS_L];
  psum_t bsum, wsum;

  always_comb begin
    bsum = '0;
    for (int j = 0; j < BYTES_L; j++) begin
      pb[j] = $signed({1'b0, a[8*j +: 8]}) * $signed(b[8*j +: 8]);
      bsum  = bsum + {{(SUM_W-BPROD_W){pb[j][BPROD_W-1]}}, pb[j]};
    end
    wsum = '0;
    for (int w = 0; w < WORDS_L; w++) begin
      pw[w] = $signed(a[16*w +: 16]) * $signed(b[16*w +: 16]);
      wsum  = wsum + {{(SUM_W-WPROD_W){pw[w][WPROD_W-1]}}, pw[w]};
    end
    psum = word_mode ? wsum : bsum;
  end
endmodule

// File: rtl/dpa_lane_fin.sv
module dpa_lane_fin
  import dpa_pkg::*;
(
  input  lane_t acc,
  input  psum_t psum,
  input  logic  sat_en,
  input  logic  sel,
  input  logic  zero_fill,
  output lane_t res
);
  localparam tot_t MAXV = tot_t'((64'sd1 <<< (LANE_W-1)) - 64'sd1);
  localparam tot_t MINV = -tot_t'(64'sd1 <<< (LANE_W-1));
  tot_t  total;
  lane_t upd;

  always_comb begin
    total = {{(TOT_W-LANE_W){acc[LANE_W-1]}}, acc} + {psum[SUM_W-1], psum};
    if (sat_en && total > MAXV)      upd = MAXV[LANE_W-1:0];
    else if (sat_en && total < MINV) upd = MINV[LANE_W-1:0];
    else                             upd = total[LANE_W-1:0];
    if (sel)            res = upd;
    else if (zero_fill) res = '0;
    else                res = acc;
  end
endmodule

// File: rtl/dpa_top.sv
module dpa_top
  import dpa_pkg::*;
#(
  parameter int LANES = 16,
  localparam int VEC_W = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             word_mode,
  input  logic             sat_en,
  input  logic             zero_fill,
  input  logic             mask_en,
  input  logic [LANES-1:0] lane_mask,
  input  logic [VEC_W-1:0] acc_in,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  output logic             out_valid,
  output logic [VEC_W-1:0] acc_out
);
  // stage 1 control
  logic             v1_q, sat1_q, zf1_q;
  logic [LANES-1:0] sel1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q      <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v1_q      <= in_valid;
      out_valid <= v1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      sat1_q <= sat_en;
      zf1_q  <= zero_fill;
      sel1_q <= mask_en ? lane_mask : '1;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    psum_t psum_d, psum_q;
    lane_t acc1_q, res_d, res_q;

    dpa_lane_mul u_mul (
      .a        (src_a[l*LANE_W +: LANE_W]),
      .b        (src_b[l*LANE_W +: LANE_W]),
      .word_mode(word_mode),
      .psum     (psum_d)
    );

    always_ff @(posedge clk) begin
      if (in_valid) begin
        psum_q <= psum_d;
        acc1_q <= acc_in[l*LANE_W +: LANE_W];
      end
    end

    dpa_lane_fin u_fin (
      .acc      (acc1_q),
      .psum     (psum_q),
      .sat_en   (sat1_q),
      .sel      (sel1_q[l]),
      .zero_fill(zf1_q),
      .res      (res_d)
    );

    always_ff @(posedge clk) begin
      if (rst)       res_q <= '0;
      else if (v1_q) res_q <= res_d;
    end

    assign acc_out[l*LANE_W +: LANE_W] = res_q;
  end
endmodule

// File: rtl/dpa_checker.sv
module dpa_checker
  import dpa_pkg::*;
#(
  parameter int LANES = 16,
  localparam int VEC_W = LANES * LANE_W
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             zero_fill,
  input logic             mask_en,
  input logic [LANES-1:0] lane_mask,
  input logic [VEC_W-1:0] acc_in,
  input logic             out_valid,
  input logic [VEC_W-1:0] acc_out
);
  logic [VEC_W-1:0] wmask;
  always_comb
    for (int l = 0; l < LANES; l++)
      wmask[l*LANE_W +: LANE_W] = {LANE_W{lane_mask[l]}};

  // R5: unselected lanes cleared under zero fill
  a_r5_zero_fill: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(mask_en, 2) && $past(zero_fill, 2))
      |-> ((acc_out & ~$past(wmask, 2)) == '0));

  // R6: unselected lanes pass the accumulator under merging
  a_r6_merge_keep: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(mask_en, 2) && !$past(zero_fill, 2))
      |-> ((acc_out & ~$past(wmask, 2)) == ($past(acc_in, 2) & ~$past(wmask, 2))));

  // R8: result two edges after issue
  a_r8_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid);

  // R8: no result without an issue
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##1 !out_valid);

  // R8: output held between results
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(acc_out));
endmodule

bind dpa_top dpa_checker #(.LANES(LANES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .zero_fill(zero_fill),
  .mask_en  (mask_en),
  .lane_mask(lane_mask),
  .acc_in   (acc_in),
  .out_valid(out_valid),
  .acc_out  (acc_out)
);

// File: tb/tb_dpa_top.sv
`timescale 1ns/1ps
module tb_dpa_top;
  localparam int L = 16;
  localparam int W = L * 32;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 0, word_mode = 0, sat_en = 0, zero_fill = 0, mask_en = 0;
  logic [L-1:0] lane_mask = '0;
  logic [W-1:0] acc_in = '0, src_a = '0, src_b = '0;
  logic out_valid;
  logic [W-1:0] acc_out;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  dpa_top #(.LANES(L)) dut (.*);

  function automatic logic [W-1:0] rnd();
    logic [W-1:0] v;
    for (int i = 0; i < L; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [W-1:0] model(input logic [W-1:0] a, b, acc,
      input logic wm, sat, zf, me, input logic [L-1:0] mk);
    logic [W-1:0] r;
    longint s, t;
    for (int l = 0; l < L; l++) begin
      s = 0;
      if (!wm)
        for (int j = 0; j < 4; j++)
          s += longint'($unsigned(a[32*l+8*j +: 8])) * longint'($signed(b[32*l+8*j +: 8]));
      else
        for (int w = 0; w < 2; w++)
          s += longint'($signed(a[32*l+16*w +: 16])) * longint'($signed(b[32*l+16*w +: 16]));
      t = longint'($signed(acc[32*l +: 32])) + s;
      if (sat && t > 64'sd2147483647)  t = 64'sd2147483647;
      if (sat && t < -64'sd2147483648) t = -64'sd2147483648;
      if (!me || mk[l]) r[32*l +: 32] = t[31:0];
      else              r[32*l +: 32] = zf ? 32'h0 : acc[32*l +: 32];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_op(input logic [W-1:0] a, b, acc, input logic wm, sat, zf, me,
                        input logic [L-1:0] mk);
    src_a = a; src_b = b; acc_in = acc; word_mode = wm; sat_en = sat;
    zero_fill = zf; mask_en = me; lane_mask = mk; in_valid = 1'b1;
  endtask

  // single op: issue at negedge, sample at the negedge after the second rising edge
  task automatic run_op(input string req, input logic [W-1:0] a, b, acc,
                        input logic wm, sat, zf, me, input logic [L-1:0] mk);
    logic [W-1:0] exp;
    exp = model(a, b, acc, wm, sat, zf, me, mk);
    @(negedge clk); set_op(a, b, acc, wm, sat, zf, me, mk);
    @(negedge clk); in_valid = 1'b0; src_a = rnd(); acc_in = rnd();
    @(negedge clk);
    chk({req, " valid"}, W'(out_valid), W'(1));
    chk(req, acc_out, exp);
  endtask

  task automatic t_reset();
    chk("R9 valid", W'(out_valid), W'(0));
    chk("R9 data", acc_out, '0);
  endtask

  task automatic t_byte();
    run_op("R1 extremes", {L{32'hFFFF_FFFF}}, {L{32'h8080_8080}}, '0, 0, 0, 0, 0, '0);
    run_op("R1 mixed", {L{32'h0102_FF80}}, {L{32'h7F80_FF02}}, {L{32'h0000_1000}}, 0, 0, 0, 0, '0);
    for (int k = 0; k < 4; k++)
      run_op("R1 random", rnd(), rnd(), rnd(), 0, 0, 0, 0, '0);
  endtask

  task automatic t_word();
    run_op("R2 fixed", {L{32'h8000_7FFF}}, {L{32'h8000_8001}}, '0, 1, 0, 0, 0, '0);
    for (int k = 0; k < 4; k++)
      run_op("R2 random", rnd(), rnd(), rnd(), 1, 0, 0, 0, '0);
  endtask

  task automatic t_wrap();
    // word 0 = 1 x 1 added to max positive wraps to min negative
    run_op("R3 wrap", {L{32'h0000_0001}}, {L{32'h0000_0001}}, {L{32'h7FFF_FFFF}}, 1, 0, 0, 0, '0);
    chk("R3 lane0", acc_out[31:0], 32'h8000_0000);
  endtask

  task automatic t_sat();
    run_op("R4 clamp high", {L{32'h0000_0001}}, {L{32'h0000_0001}}, {L{32'h7FFF_FFFF}}, 1, 1, 0, 0, '0);
    chk("R4 high lane0", acc_out[31:0], 32'h7FFF_FFFF);
    run_op("R4 clamp low", {L{32'h0000_0001}}, {L{32'h0000_FFFF}}, {L{32'h8000_0000}}, 1, 1, 0, 0, '0);
    chk("R4 low lane0", acc_out[31:0], 32'h8000_0000);
    // product sum 2^31 alone overflows; with acc -100 final is in range
    run_op("R4 final only", {L{32'h8000_8000}}, {L{32'h8000_8000}}, {L{32'hFFFF_FF9C}}, 1, 1, 0, 0, '0);
    chk("R4 final lane0", acc_out[31:0], 32'h7FFF_FF9C);
    run_op("R4 random byte", rnd(), rnd(), rnd(), 0, 1, 0, 0, '0);
  endtask

  task automatic t_zero();
    run_op("R5 zero fill", rnd(), rnd(), rnd(), 0, 0, 1, 1, 16'hA5C3);
    run_op("R5 none sel", rnd(), rnd(), rnd(), 1, 0, 1, 1, 16'h0000);
  endtask

  task automatic t_merge();
    run_op("R6 merge", rnd(), rnd(), rnd(), 1, 1, 0, 1, 16'h3C0F);
    run_op("R6 merge byte", rnd(), rnd(), rnd(), 0, 0, 0, 1, 16'h8001);
  endtask

  task automatic t_nomask();
    run_op("R7 mask off", rnd(), rnd(), rnd(), 0, 0, 1, 0, 16'h0000);
    run_op("R7 mask off merge", rnd(), rnd(), rnd(), 1, 0, 0, 0, 16'h1234);
  endtask

  task automatic t_pipe();
    logic [W-1:0] a0, b0, c0, a1, b1, c1, e0, e1, held;
    a0 = rnd(); b0 = rnd(); c0 = rnd(); a1 = rnd(); b1 = rnd(); c1 = rnd();
    e0 = model(a0, b0, c0, 0, 1, 1, 1, 16'h00FF);
    e1 = model(a1, b1, c1, 1, 0, 0, 1, 16'hF0F0);
    @(negedge clk); set_op(a0, b0, c0, 0, 1, 1, 1, 16'h00FF);
    @(negedge clk); set_op(a1, b1, c1, 1, 0, 0, 1, 16'hF0F0);
    @(negedge clk); in_valid = 1'b0; acc_in = rnd();
    chk("R8 first", acc_out, e0);
    chk("R8 first valid", W'(out_valid), W'(1));
    @(negedge clk);
    chk("R8 second", acc_out, e1);
    chk("R8 second valid", W'(out_valid), W'(1));
    held = acc_out;
    @(negedge clk);
    chk("R8 idle valid", W'(out_valid), W'(0));
    chk("R8 hold", acc_out, held);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_byte();
    t_word();
    t_wrap();
    t_sat();
    t_zero();
    t_merge();
    t_nomask();
    t_pipe();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule